// File: doc/BRIEF.md
# Dual-mode 40-bit accumulator ALU

This block is the arithmetic and logic stage of a fixed-point datapath. It holds two 40-bit accumulators, A and B. Each accumulator has an 8-bit guard field on top, then a 16-bit high word, then a 16-bit low word. Each operation reads the destination accumulator as its first operand. The second operand is either the other accumulator or a 16-bit data word widened to 40 bits. The result is written back into the destination on the next clock edge.

Three mode inputs shape each operation:
- Sign-extension mode chooses how the data word is widened.
- Overflow mode chooses between clamping a result that has left the 32-bit range and keeping the wrapped value, with the guard bits holding the extra magnitude.
- Dual mode splits add and subtract into two independent 16-bit lanes that share no carry.

A carry flag records the carry of the last add or subtract. Each accumulator has its own sticky overflow flag, which only an explicit clear input resets. Any field of either accumulator can be loaded directly from a 16-bit word.

Top module: `gacc_alu`

## Requirements
- R1: While rst_ni is low, both accumulators, the carry flag and both overflow flags are 0.
- R2: With dual_i=0, op_i=0 (add) and op_i=1 (subtract) write (dst ± operand) mod 2^40 into the destination one clock after valid_i when ovm_i=0. The destination is A for dst_i=0 and B for dst_i=1. The operand is the other accumulator when src_acc_i=1, otherwise the widened data_i.
- R3: After an add, carry_o is the unsigned carry out of the top bit. After a subtract (computed as dst + ~operand + 1), carry_o is that same carry out, so it is 1 when there is no borrow. In dual mode the carry is taken from the high lane. carry_o is not changed by logic ops, no-op codes, field writes or idle cycles.
- R4: With sxm_i=1, data_i is sign extended to 40 bits. With sxm_i=0, it is zero extended.
- R5: In 40-bit mode with ovm_i=1, an add or subtract whose exact result lies outside [-2^31, 2^31-1] writes 0x00_7FFF_FFFF if the result is positive and 0xFF_8000_0000 if it is negative.
- R6: An add or subtract sets the destination's overflow flag when its exact result leaves the range checked by the mode: 32 bits signed in 40-bit mode, 16 bits signed in either lane in dual mode. The flag stays at 1 until clr_ov_i (bit 0 for A, bit 1 for B) is 1 while it is not being set. Setting wins over clearing.
- R7: With dual_i=1, add and subtract work on bits 31:16 and 15:0 as separate lanes. There is no carry from bit 15 into bit 16. In data mode each lane takes the raw data_i as its operand. The guard field receives copies of the high lane's sign bit.
- R8: In dual mode with ovm_i=1, a lane that overflows its 16-bit signed range is clamped to 0x7FFF or 0x8000.
- R9: op_i=2, 3 and 4 write AND, OR and XOR of the full 40-bit operands, whatever the state of dual_i and ovm_i. They set no overflow flag. op_i codes 5 to 7 leave the accumulator unchanged.
- R10: With valid_i=0 and wr_en_i=1, wr_field_i selects the field of accumulator wr_acc_i that is loaded: 0 loads the guard field from wr_data_i[7:0], 1 loads the high word, 2 loads the low word, and 3 changes nothing. When valid_i=1, the field write is ignored.
- R11: An operation changes only its destination accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Perform an operation this cycle |
| op_i | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor, 5-7 none |
| dst_i | input | 1 | Destination accumulator (0 A, 1 B) |
| src_acc_i | input | 1 | Second operand is the other accumulator |
| data_i | input | 16 | Data word operand |
| sxm_i | input | 1 | Sign-extend the data word |
| ovm_i | input | 1 | Saturate on overflow |
| dual_i | input | 1 | Two 16-bit lanes for add and subtract |
| wr_en_i | input | 1 | Field load enable |
| wr_acc_i | input | 1 | Accumulator for the field load |
| wr_field_i | input | 2 | Field: 0 guard, 1 high, 2 low |
| wr_data_i | input | 16 | Field load value |
| clr_ov_i | input | 2 | Overflow flag clear, bit 0 for A, bit 1 for B |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| carry_o | output | 1 | Carry flag |
| ov_a_o | output | 1 | Sticky overflow flag of A |
| ov_b_o | output | 1 | Sticky overflow flag of B |

## Verification
Directed operands placed just inside and just outside the 32-bit range show whether saturation is applied and that the guard bits keep growth when it is off. Data words with the top bit set, widened once with sign extension and once without, show the two extension modes. Lane operands where the low lane rolls over from 0xFFFF while the high lane sits at 0x7FFF show that no carry crosses bit 15 and that each lane clamps on its own. A long run of random operations, modes, clears and field loads is checked against a 64-bit integer model and covers the remaining combinations.

// File: rtl/gacc_pkg.sv
package gacc_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    FLD_GUARD = 2'd0,
    FLD_HIGH  = 2'd1,
    FLD_LOW   = 2'd2
  } field_e;

  localparam int NUM_ACC = 2;
  localparam int NUM_LANE = 2;
endpackage

// File: rtl/gacc_addsat.sv
// Add/subtract with signed range check at SW bits and optional clamp.
module gacc_addsat #(
  parameter int W  = 40,
  parameter int SW = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         sat_en_i,
  output logic [W-1:0] res_o,
  output logic         ov_o
);
  localparam logic [W-1:0] SAT_MAX = {{(W-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic [W-1:0] SAT_MIN = {{(W-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W:0]   exact;

  assign b_eff = sub_i ? ~b_i : b_i;
  // one extra bit holds the exact two's complement result
  assign exact = {a_i[W-1], a_i} + {b_eff[W-1], b_eff} + {{W{1'b0}}, sub_i};
  assign ov_o  = !((&exact[W:SW-1]) || !(|exact[W:SW-1]));

  always_comb begin
    if (sat_en_i && ov_o) res_o = exact[W] ? SAT_MIN : SAT_MAX;
    else                  res_o = exact[W-1:0];
  end
endmodule

// File: rtl/gacc_datapath.sv
module gacc_datapath
  import gacc_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input  op_e                             op_i,
  input  logic [GUARD_W+2*WORD_W-1:0]     x_i,
  input  logic [GUARD_W+2*WORD_W-1:0]     other_i,
  input  logic [WORD_W-1:0]               data_i,
  input  logic                            src_acc_i,
  input  logic                            sxm_i,
  input  logic                            ovm_i,
  input  logic                            dual_i,
  output logic [GUARD_W+2*WORD_W-1:0]     res_o,
  output logic                            cout_o,
  output logic                            ov_o,
  output logic                            arith_o
);
  localparam int ACC_W = GUARD_W + 2*WORD_W;
  localparam int SAT_W = 2*WORD_W;

  logic [ACC_W-1:0]  ext, y, y_eff, w_res;
  logic              w_ov, sub, c_wide, c_hi;
  logic [WORD_W-1:0] lane_res [NUM_LANE];
  logic [NUM_LANE-1:0] lane_ov;
  logic [WORD_W-1:0] yh_eff;

  assign sub     = (op_i == OP_SUB);
  assign arith_o = (op_i == OP_ADD) || sub;
  assign ext     = sxm_i ? {{(ACC_W-WORD_W){data_i[WORD_W-1]}}, data_i}
                         : {{(ACC_W-WORD_W){1'b0}}, data_i};
  assign y       = src_acc_i ? other_i : ext;

  gacc_addsat #(.W(ACC_W), .SW(SAT_W)) u_wide (
    .a_i(x_i), .b_i(y), .sub_i(sub), .sat_en_i(ovm_i),
    .res_o(w_res), .ov_o(w_ov)
  );

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    logic [WORD_W-1:0] lx, ly;
    assign lx = x_i[g*WORD_W +: WORD_W];
    assign ly = src_acc_i ? other_i[g*WORD_W +: WORD_W] : data_i;
    gacc_addsat #(.W(WORD_W), .SW(WORD_W)) u_lane (
      .a_i(lx), .b_i(ly), .sub_i(sub), .sat_en_i(ovm_i),
      .res_o(lane_res[g]), .ov_o(lane_ov[g])
    );
  end

  // unsigned carries: top of the 40-bit path and top of the high lane
  assign y_eff  = sub ? ~y : y;
  assign yh_eff = sub ? ~(src_acc_i ? other_i[2*WORD_W-1:WORD_W] : data_i)
                      :  (src_acc_i ? other_i[2*WORD_W-1:WORD_W] : data_i);
  assign c_wide = 1'(({1'b0, x_i} + {1'b0, y_eff} + {{ACC_W{1'b0}}, sub}) >> ACC_W);
  assign c_hi   = 1'(({1'b0, x_i[2*WORD_W-1:WORD_W]} + {1'b0, yh_eff}
                      + {{WORD_W{1'b0}}, sub}) >> WORD_W);

  always_comb begin
    res_o  = x_i;
    cout_o = 1'b0;
    ov_o   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        if (dual_i) begin
          res_o  = {{GUARD_W{lane_res[1][WORD_W-1]}}, lane_res[1], lane_res[0]};
          cout_o = c_hi;
          ov_o   = |lane_ov;
        end else begin
          res_o  = w_res;
          cout_o = c_wide;
          ov_o   = w_ov;
        end
      end
      OP_AND:  res_o = x_i & y;
      OP_OR:   res_o = x_i | y;
      OP_XOR:  res_o = x_i ^ y;
      default: res_o = x_i;
    endcase
  end
endmodule

// File: rtl/gacc_alu.sv
module gacc_alu
  import gacc_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [2:0]                    op_i,
  input  logic                          dst_i,
  input  logic                          src_acc_i,
  input  logic [WORD_W-1:0]             data_i,
  input  logic                          sxm_i,
  input  logic                          ovm_i,
  input  logic                          dual_i,
  input  logic                          wr_en_i,
  input  logic                          wr_acc_i,
  input  logic [1:0]                    wr_field_i,
  input  logic [WORD_W-1:0]             wr_data_i,
  input  logic [NUM_ACC-1:0]            clr_ov_i,
  output logic [GUARD_W+2*WORD_W-1:0]   acc_a_o,
  output logic [GUARD_W+2*WORD_W-1:0]   acc_b_o,
  output logic                          carry_o,
  output logic                          ov_a_o,
  output logic                          ov_b_o
);
  localparam int ACC_W = GUARD_W + 2*WORD_W;

  op_e              op;
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [NUM_ACC-1:0] ov_q;
  logic [ACC_W-1:0] x_acc, other_acc, dp_res;
  logic             dp_cout, dp_ov, dp_arith, carry_q;

  assign op        = op_e'(op_i);
  assign x_acc     = acc_q[dst_i];
  assign other_acc = acc_q[~dst_i];

  gacc_datapath #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) u_dp (
    .op_i(op), .x_i(x_acc), .other_i(other_acc), .data_i(data_i),
    .src_acc_i(src_acc_i), .sxm_i(sxm_i), .ovm_i(ovm_i), .dual_i(dual_i),
    .res_o(dp_res), .cout_o(dp_cout), .ov_o(dp_ov), .arith_o(dp_arith)
  );

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    logic [ACC_W-1:0] q;
    logic             ovf;
    logic             hit, fld_hit;

    assign hit     = valid_i && (dst_i == 1'(k));
    assign fld_hit = !valid_i && wr_en_i && (wr_acc_i == 1'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (hit) begin
        q <= dp_res;
      end else if (fld_hit) begin
        unique case (wr_field_i)
          FLD_GUARD: q[ACC_W-1 -: GUARD_W]    <= wr_data_i[GUARD_W-1:0];
          FLD_HIGH:  q[2*WORD_W-1 -: WORD_W]  <= wr_data_i;
          FLD_LOW:   q[WORD_W-1:0]            <= wr_data_i;
          default:   q <= q;
        endcase
      end
    end

    // sticky flag: set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              ovf <= 1'b0;
      else if (hit && dp_ov)    ovf <= 1'b1;
      else if (clr_ov_i[k])     ovf <= 1'b0;
    end

    assign acc_q[k] = q;
    assign ov_q[k]  = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  carry_q <= 1'b0;
    else if (valid_i && dp_arith) carry_q <= dp_cout;
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign carry_o = carry_q;
  assign ov_a_o  = ov_q[0];
  assign ov_b_o  = ov_q[1];

  // R6
  ov_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q[0] && !clr_ov_i[0]) |=> ov_q[0]);

  // R3
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i <= 3'd1)) |=> $stable(carry_q));

  // R11
  other_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dst_i) |=> $stable(acc_q[1]));

  // R5
  sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dst_i && ovm_i && !dual_i && (op_i <= 3'd1))
      |=> ((acc_q[0][ACC_W-1:2*WORD_W-1] == '0) || (&acc_q[0][ACC_W-1:2*WORD_W-1])));

  // R7
  dual_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dst_i && dual_i && (op_i <= 3'd1))
      |=> (acc_q[1][ACC_W-1:2*WORD_W] == {GUARD_W{acc_q[1][2*WORD_W-1]}}));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (carry_q == 1'b0 && ov_q == '0);
    end
  end
endmodule

// File: tb/sim_gacc_alu.sv
module sim_gacc_alu;
  localparam int CLK_T = 10;
  localparam longint M40 = 64'hFF_FFFF_FFFF;
  localparam longint P31 = 64'sd2147483647;
  localparam longint N31 = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        dst_i = 1'b0, src_acc_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        sxm_i = 1'b0, ovm_i = 1'b0, dual_i = 1'b0;
  logic        wr_en_i = 1'b0, wr_acc_i = 1'b0;
  logic [1:0]  wr_field_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  clr_ov_i = '0;
  logic [39:0] acc_a_o, acc_b_o;
  logic        carry_o, ov_a_o, ov_b_o;

  gacc_alu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .dst_i(dst_i),
    .src_acc_i(src_acc_i), .data_i(data_i), .sxm_i(sxm_i), .ovm_i(ovm_i),
    .dual_i(dual_i), .wr_en_i(wr_en_i), .wr_acc_i(wr_acc_i), .wr_field_i(wr_field_i),
    .wr_data_i(wr_data_i), .clr_ov_i(clr_ov_i), .acc_a_o(acc_a_o), .acc_b_o(acc_b_o),
    .carry_o(carry_o), .ov_a_o(ov_a_o), .ov_b_o(ov_b_o)
  );

  always #(CLK_T/2) clk = ~clk;

  typedef struct {
    longint a, b;
    bit c, oa, ob;
    string tag;
  } exp_t;

  exp_t   sb_q[$];
  int     checks = 0, failures = 0;
  bit     done = 1'b0;
  longint ma = 0, mb = 0;
  bit     mc = 0, moa = 0, mob = 0;

  function automatic longint s40(longint v);
    longint t = v & M40;
    return (t ^ 64'h80_0000_0000) - 64'h80_0000_0000;
  endfunction

  function automatic longint s16(longint v);
    longint t = v & 64'hFFFF;
    return (t ^ 64'h8000) - 64'h8000;
  endfunction

  task automatic drive(bit v, bit [2:0] op, bit dst, bit src, bit [15:0] d,
                       bit sxm, bit ovm, bit dual, bit we, bit wacc,
                       bit [1:0] wf, bit [15:0] wd, bit [1:0] clr, string tag);
    longint x, o, y, r, ex;
    bit c, ov, setf;
    exp_t e;
    @(negedge clk);
    valid_i = v; op_i = op; dst_i = dst; src_acc_i = src; data_i = d;
    sxm_i = sxm; ovm_i = ovm; dual_i = dual; wr_en_i = we; wr_acc_i = wacc;
    wr_field_i = wf; wr_data_i = wd; clr_ov_i = clr;
    setf = 0;
    if (v) begin
      x = dst ? mb : ma;
      o = dst ? ma : mb;
      y = src ? o : (sxm ? (s16(longint'(d)) & M40) : longint'(d));
      c = mc; ov = 0; r = x;
      if (op <= 3'd1) begin
        if (!dual) begin
          ex = (op == 3'd1) ? s40(x) - s40(y) : s40(x) + s40(y);
          ov = (ex > P31) || (ex < N31);
          c  = (op == 3'd1) ? bit'(((x + ((~y) & M40) + 1) >> 40) & 1)
                            : bit'(((x + y) >> 40) & 1);
          r  = (ovm && ov) ? ((ex < 0) ? 64'hFF_8000_0000 : 64'h7FFF_FFFF) : (ex & M40);
        end else begin
          longint rl[2];
          for (int g = 0; g < 2; g++) begin
            longint xl, yl, el;
            bit lo;
            xl = (x >> (16*g)) & 64'hFFFF;
            yl = src ? ((o >> (16*g)) & 64'hFFFF) : longint'(d);
            el = (op == 3'd1) ? s16(xl) - s16(yl) : s16(xl) + s16(yl);
            lo = (el > 32767) || (el < -32768);
            ov = ov | lo;
            rl[g] = (ovm && lo) ? ((el < 0) ? 64'h8000 : 64'h7FFF) : (el & 64'hFFFF);
            if (g == 1)
              c = (op == 3'd1) ? bit'(((xl + ((~yl) & 64'hFFFF) + 1) >> 16) & 1)
                               : bit'(((xl + yl) >> 16) & 1);
          end
          r = ((s16(rl[1]) << 16) | rl[0]) & M40;
        end
        mc = c;
      end else if (op == 3'd2) r = x & y;
      else if (op == 3'd3) r = x | y;
      else if (op == 3'd4) r = x ^ y;
      if (dst) mb = r; else ma = r;
      setf = ov;
    end else if (we) begin
      longint m, val;
      case (wf)
        2'd0: begin m = 64'hFF_0000_0000; val = longint'(wd & 16'hFF) << 32; end
        2'd1: begin m = 64'h00_FFFF_0000; val = longint'(wd) << 16; end
        2'd2: begin m = 64'h00_0000_FFFF; val = longint'(wd); end
        default: begin m = 0; val = 0; end
      endcase
      if (wacc) mb = (mb & ~m) | val; else ma = (ma & ~m) | val;
    end
    if (setf && !dst) moa = 1; else if (clr[0]) moa = 0;
    if (setf && dst)  mob = 1; else if (clr[1]) mob = 0;
    e.a = ma; e.b = mb; e.c = mc; e.oa = moa; e.ob = mob; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic alu(bit [2:0] op, bit dst, bit src, bit [15:0] d,
                     bit sxm, bit ovm, bit dual, string tag);
    drive(1, op, dst, src, d, sxm, ovm, dual, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fld(bit acc, bit [1:0] f, bit [15:0] d, string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, acc, f, d, 0, tag);
  endtask

  task automatic load(bit acc, bit [7:0] gd, bit [15:0] hi, bit [15:0] lo, string tag);
    fld(acc, 2'd0, {8'h00, gd}, tag);
    fld(acc, 2'd1, hi, tag);
    fld(acc, 2'd2, lo, tag);
  endtask

  task automatic clr(bit [1:0] m, string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, m, tag);
  endtask

  // monitor: compares one expected item per clock, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (longint'(acc_a_o) != e.a || longint'(acc_b_o) != e.b || carry_o != e.c ||
          ov_a_o != e.oa || ov_b_o != e.ob) begin
        failures++;
        $display("FAIL %s: actual a=%h b=%h c=%0d ova=%0d ovb=%0d expected a=%h b=%h c=%0d ova=%0d ovb=%0d",
                 e.tag, acc_a_o, acc_b_o, carry_o, ov_a_o, ov_b_o,
                 e.a[39:0], e.b[39:0], e.c, e.oa, e.ob);
      end
    end
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (acc_a_o !== '0 || acc_b_o !== '0 || carry_o !== 1'b0 || ov_a_o !== 1'b0 || ov_b_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual a=%h b=%h c=%b ova=%b ovb=%b expected all zero",
               acc_a_o, acc_b_o, carry_o, ov_a_o, ov_b_o);
    end
    rst_ni = 1'b1;

    // R10 field loads, including the unused field code
    load(0, 8'h00, 16'h7FFF, 16'hFFF0, "R10 load A");
    fld(0, 2'd3, 16'hABCD, "R10 field code 3 ignored");
    // R2 wrap into guard bits, R6 flag set
    alu(0, 0, 0, 16'h0020, 0, 0, 0, "R2 add past 32-bit range");
    clr(2'b00, "R6 flag sticky");
    clr(2'b01, "R6 flag clear A");
    // R5 positive clamp
    load(0, 8'h00, 16'h7FFF, 16'hFFF0, "R10 reload A");
    alu(0, 0, 0, 16'h0020, 0, 1, 0, "R5 clamp positive");
    // R5 negative clamp, R6 set wins over clear
    load(1, 8'hFF, 16'h8000, 16'h0005, "R10 load B");
    drive(1, 1, 1, 0, 16'h0010, 0, 1, 0, 0, 0, 0, 0, 2'b10, "R5 R6 clamp negative, set beats clear");
    // R4 extension modes
    load(0, 8'h00, 16'h0000, 16'h0000, "R10 zero A");
    alu(0, 0, 0, 16'h8000, 1, 0, 0, "R4 sign extended");
    alu(0, 0, 0, 16'h8000, 0, 0, 0, "R4 zero extended");
    // R3 carry out of bit 39 and borrow
    load(0, 8'hFF, 16'hFFFF, 16'hFFFF, "R10 all ones A");
    alu(0, 0, 0, 16'h0001, 0, 0, 0, "R3 carry out add");
    alu(1, 0, 0, 16'h0001, 0, 0, 0, "R3 borrow sub");
    alu(2, 0, 0, 16'h0F0F, 0, 0, 0, "R3 R9 logic keeps carry");
    // R7 lanes, R8 lane clamp
    load(0, 8'h00, 16'h7FFF, 16'hFFFF, "R10 lanes A");
    alu(0, 0, 0, 16'h0001, 0, 0, 1, "R7 dual add no cross carry");
    load(0, 8'h00, 16'h7FFF, 16'hFFFF, "R10 lanes A again");
    alu(0, 0, 0, 16'h0001, 0, 1, 1, "R8 dual clamp high lane");
    load(1, 8'h00, 16'h8000, 16'h8000, "R10 lanes B");
    alu(1, 1, 0, 16'h0001, 0, 1, 1, "R8 dual clamp both lanes");
    // R11 accumulator source, R9 logic ops
    alu(0, 0, 1, 16'h0000, 0, 0, 0, "R11 A plus B");
    alu(3, 1, 1, 16'h0000, 0, 0, 0, "R9 or into B");
    alu(4, 1, 0, 16'hFFFF, 1, 1, 1, "R9 xor ignores modes");
    alu(5, 0, 0, 16'h1234, 0, 0, 0, "R9 no-op code");
    // R10 op beats field write
    drive(1, 2, 0, 0, 16'h00FF, 0, 0, 0, 1, 0, 2'd2, 16'h5555, 0, "R10 op priority");

    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 3) != 0, 3'($urandom_range(0, 6)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 16'($urandom),
            2'($urandom_range(0, 3)), "R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 random");
    end
    clr(2'b00, "R3 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule